// File: doc/BRIEF.md
# Quad SPI Execute-in-Place Read Engine

This block serves 32-bit word reads from a simple request/response port by running quad-I/O fast-read transactions on a serial NOR flash. A request carries a 24-bit byte address. The engine lowers chip select and, on the first access since reset or since it was last enabled, shifts the 8-bit read command out serially on data line 0. It then drives the address and a mode byte on all four lines, leaves the lines released for a programmable number of dummy clocks, and captures eight data nibbles. The response is one word with the flash bytes arranged little-endian.

The mode byte sent after the address keeps the flash in continuous-read mode. After the first completed transaction, every later access therefore starts directly with the quad address. The serial clock is the system clock divided by a programmable half-period. Read data is captured a programmable number of system clocks after the system edge that raises the serial clock, which absorbs the pad and board round trip. Dropping the enable input clears the continuous-mode state, so the next access sends the command again.

Top module: `qspi_xip_reader`

## Requirements
- R1: The first transaction after reset, or after `en` returns high, starts with the 8-bit read command (parameter, default 0xEB). The command goes most significant bit first on `io_out[0]`, one bit per rising edge of `sclk`, with `io_oe` = 4'b0001.
- R2: The 24-bit address follows as six nibbles, most significant first, with `io_out[3]` carrying the top bit of each nibble. The mode byte 0xA0 follows as two nibbles, 0xA then 0x0. `io_oe` is 4'b1111 for these eight clocks.
- R3: After the mode byte come `cfg_dummy` clocks and then eight data clocks, all with `io_oe` = 4'b0000. A transaction therefore has 16 + `cfg_dummy` rising edges of `sclk`, plus 8 when the command is sent.
- R4: Within each byte, the first nibble received is the upper nibble. The k-th byte received, which sits at address+k, lands in `rsp_data[8k+7:8k]`.
- R5: Once a transaction has completed, every later access omits the command, so its first rising edge already carries the top address nibble.
- R6: While `en` is low, `req_ready` is low and a pending request does not lower `cs_n`. After `en` rises again, the next access sends the command.
- R7: Each accepted request produces exactly one response. `rsp_valid` is high for one cycle and `rsp_data` is valid in that cycle. `req_ready` is low from acceptance until that cycle.
- R8: Between two transactions, `cs_n` stays high for at least one serial clock period (2·`cfg_div` system clocks).
- R9: `sclk` is low whenever `cs_n` is high. During a transaction, each high phase and each low phase of `sclk` lasts `cfg_div` system clocks. A `cfg_div` of 0 acts as 1.
- R10: During the data phase, `io_in` is sampled `cfg_dly` system clocks after the system clock edge that raises `sclk`. Values of `cfg_dly` from 0 up to `cfg_div` are supported.
- R11: Out of reset, `cs_n` is 1, `sclk` is 0, `io_oe` is 0 and `rsp_valid` is 0, and `req_ready` follows `en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Engine enable; low clears continuous mode |
| cfg_div | input | DIV_W | Serial clock half-period in system clocks |
| cfg_dummy | input | DUMMY_W | Dummy clocks after the mode byte |
| cfg_dly | input | DLY_W | Read capture delay in system clocks |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Engine can accept a request |
| req_addr | input | ADDR_W | Byte address of the word |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 32 | Returned word, lowest address in bits 7:0 |
| sclk | output | 1 | Flash serial clock |
| cs_n | output | 1 | Flash chip select, active low |
| io_out | output | 4 | Data values driven toward the flash |
| io_oe | output | 4 | Per-line output enables |
| io_in | input | 4 | Data values read back from the pads |

## Verification
The bench keeps the default parameters: a 4-bit divider and dummy count, a 3-bit capture delay and a 24-bit address. It varies the runtime settings between transactions instead. Divider values of 0 through 3 and dummy counts of 0, 4 and 6 bring the shortest serial period and a transaction with no dummy phase within reach. A flash model returns data three system clocks late; paired with a capture delay of 2, it shows that the delayed sampling point is the one actually used. Back-to-back requests and an enable drop exercise the chip-select gap and the return to command mode.

// File: rtl/qxr_pkg.sv
package qxr_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD,
        PH_ADDR,
        PH_DUMMY,
        PH_DATA,
        PH_GAP
    } qxr_phase_e;

    // first byte received (lowest address) moves to the least significant lane
    function automatic logic [31:0] qxr_swap_bytes(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

endpackage

// File: rtl/qxr_halfclk.sv
module qxr_halfclk #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic [DIV_W-1:0] lim;

    always_comb begin
        lim   = (div == '0) ? DIV_W'(1) : div;
        tick  = run && (cnt_q == lim - 1'b1);
        cnt_d = cnt_q;
        if (!run || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/qxr_capture.sv
module qxr_capture #(
    parameter int DLY_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic [DLY_W-1:0] dly,
    input  logic [3:0]       nib_in,
    output logic [31:0]      word
);
    localparam int TAPS = 1 << DLY_W;

    logic [TAPS-2:0] tap_d, tap_q;
    logic [31:0]     acc_d, acc_q;
    logic            take;

    always_comb begin
        tap_d = {tap_q[TAPS-3:0], strobe};
        take  = (dly == '0) ? strobe : tap_q[dly - 1'b1];
        acc_d = take ? {acc_q[27:0], nib_in} : acc_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tap_q <= '0;
            acc_q <= '0;
        end else begin
            tap_q <= tap_d;
            acc_q <= acc_d;
        end
    end

    assign word = acc_q;
endmodule

// File: rtl/qspi_xip_reader.sv
module qspi_xip_reader #(
    parameter int          DIV_W    = 4,
    parameter int          DUMMY_W  = 4,
    parameter int          DLY_W    = 3,
    parameter int          ADDR_W   = 24,
    parameter logic [7:0]  RD_CMD   = 8'hEB,
    parameter logic [7:0]  MODE_BYTE = 8'hA0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [DIV_W-1:0]   cfg_div,
    input  logic [DUMMY_W-1:0] cfg_dummy,
    input  logic [DLY_W-1:0]   cfg_dly,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_addr,
    output logic               rsp_valid,
    output logic [31:0]        rsp_data,
    output logic               sclk,
    output logic               cs_n,
    output logic [3:0]         io_out,
    output logic [3:0]         io_oe,
    input  logic [3:0]         io_in
);
    import qxr_pkg::*;

    localparam int ADDR_NIB = ADDR_W / 4;
    localparam int MODE_NIB = 2;
    localparam int DATA_NIB = 8;
    localparam int CMD_BITS = 8;
    localparam int SH_W     = ADDR_W + 8;
    localparam int CNT_W    = (DUMMY_W > 4) ? DUMMY_W : 4;

    typedef struct packed {
        qxr_phase_e        ph;
        logic [CNT_W-1:0]  cnt;
        logic              sclk;
        logic              cs_n;
        logic              cont;
        logic [SH_W-1:0]   sh;
        logic [ADDR_W-1:0] addr;
        logic              rsp_v;
        logic [31:0]       rsp_d;
    } st_t;

    st_t              st_d, st_q;
    logic             tick;
    logic             strobe;
    logic [31:0]      word;
    logic [CNT_W-1:0] last_slot;
    logic             slot_end;

    qxr_halfclk #(.DIV_W(DIV_W)) u_halfclk (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (st_q.ph != PH_IDLE),
        .div  (cfg_div),
        .tick (tick)
    );

    qxr_capture #(.DLY_W(DLY_W)) u_capture (
        .clk   (clk),
        .rst_n (rst_n),
        .strobe(strobe),
        .dly   (cfg_dly),
        .nib_in(io_in),
        .word  (word)
    );

    // rising half of a data slot is the nominal sample point
    assign strobe = (st_q.ph == PH_DATA) && tick && !st_q.sclk;

    always_comb begin
        case (st_q.ph)
            PH_CMD:   last_slot = CNT_W'(CMD_BITS - 1);
            PH_ADDR:  last_slot = CNT_W'(ADDR_NIB + MODE_NIB - 1);
            PH_DUMMY: last_slot = CNT_W'(cfg_dummy) - 1'b1;
            PH_DATA:  last_slot = CNT_W'(DATA_NIB - 1);
            default:  last_slot = CNT_W'(1);
        endcase
        slot_end = (st_q.cnt == last_slot);
    end

    always_comb begin
        st_d       = st_q;
        st_d.rsp_v = 1'b0;
        case (st_q.ph)
            PH_IDLE: begin
                if (req_valid && en) begin
                    st_d.cs_n = 1'b0;
                    st_d.sclk = 1'b0;
                    st_d.cnt  = '0;
                    st_d.addr = req_addr;
                    if (st_q.cont) begin
                        st_d.ph = PH_ADDR;
                        st_d.sh = {req_addr, MODE_BYTE};
                    end else begin
                        st_d.ph = PH_CMD;
                        st_d.sh = {RD_CMD, {(SH_W-8){1'b0}}};
                    end
                end
            end
            PH_CMD, PH_ADDR, PH_DUMMY, PH_DATA: begin
                if (tick) begin
                    if (!st_q.sclk) begin
                        st_d.sclk = 1'b1;
                    end else begin
                        st_d.sclk = 1'b0;
                        st_d.cnt  = st_q.cnt + 1'b1;
                        if (st_q.ph == PH_CMD) begin
                            st_d.sh = {st_q.sh[SH_W-2:0], 1'b0};
                        end else if (st_q.ph == PH_ADDR) begin
                            st_d.sh = {st_q.sh[SH_W-5:0], 4'b0};
                        end
                        if (slot_end) begin
                            st_d.cnt = '0;
                            case (st_q.ph)
                                PH_CMD: begin
                                    st_d.ph = PH_ADDR;
                                    st_d.sh = {st_q.addr, MODE_BYTE};
                                end
                                PH_ADDR: begin
                                    st_d.ph = (cfg_dummy == '0) ? PH_DATA : PH_DUMMY;
                                end
                                PH_DUMMY: begin
                                    st_d.ph = PH_DATA;
                                end
                                default: begin
                                    st_d.ph   = PH_GAP;
                                    st_d.cs_n = 1'b1;
                                end
                            endcase
                        end
                    end
                end
            end
            PH_GAP: begin
                if (tick) begin
                    st_d.cnt = st_q.cnt + 1'b1;
                    if (slot_end) begin
                        st_d.cnt   = '0;
                        st_d.ph    = PH_IDLE;
                        st_d.rsp_v = 1'b1;
                        st_d.rsp_d = qxr_swap_bytes(word);
                        st_d.cont  = en;
                    end
                end
            end
            default: begin
                st_d.ph   = PH_IDLE;
                st_d.cs_n = 1'b1;
                st_d.sclk = 1'b0;
            end
        endcase
        if (!en) begin
            st_d.cont = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph    <= PH_IDLE;
            st_q.cnt   <= '0;
            st_q.sclk  <= 1'b0;
            st_q.cs_n  <= 1'b1;
            st_q.cont  <= 1'b0;
            st_q.sh    <= '0;
            st_q.addr  <= '0;
            st_q.rsp_v <= 1'b0;
            st_q.rsp_d <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        io_out = 4'b0000;
        io_oe  = 4'b0000;
        if (st_q.ph == PH_CMD) begin
            io_out = {3'b000, st_q.sh[SH_W-1]};
            io_oe  = 4'b0001;
        end else if (st_q.ph == PH_ADDR) begin
            io_out = st_q.sh[SH_W-1 -: 4];
            io_oe  = 4'b1111;
        end
    end

    assign req_ready = (st_q.ph == PH_IDLE) && en;
    assign rsp_valid = st_q.rsp_v;
    assign rsp_data  = st_q.rsp_d;
    assign sclk      = st_q.sclk;
    assign cs_n      = st_q.cs_n;
endmodule

// File: rtl/qxr_checker.sv
module qxr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       sclk,
    input logic [3:0] io_oe,
    input logic       rsp_valid,
    input logic       req_ready
);
    // R7
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R7
    ready_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> cs_n);

    // R8
    cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |=> cs_n);

    // R9
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // R2
    oe_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_oe == 4'b0000) || (io_oe == 4'b0001) || (io_oe == 4'b1111));

    // R1
    oe_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_oe != 4'b0000) |-> !cs_n);
endmodule

bind qspi_xip_reader qxr_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .sclk     (sclk),
    .io_oe    (io_oe),
    .rsp_valid(rsp_valid),
    .req_ready(req_ready)
);

// File: tb/sim_qspi_xip_reader.sv
module sim_qspi_xip_reader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b1;
    logic [3:0]  cfg_div = 4'd2;
    logic [3:0]  cfg_dummy = 4'd4;
    logic [2:0]  cfg_dly = 3'd1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_addr = '0;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        sclk, cs_n;
    logic [3:0]  io_out, io_oe, io_in;

    int nchk = 0;
    int nerr = 0;
    int cyc = 0;
    int lat = 0;
    int nr = 0;
    int hc = 0;
    int gap_last = 0;
    logic [3:0] rec_o [0:63];
    logic [3:0] rec_e [0:63];
    int rise_cyc [0:63];
    logic [3:0] raw = 4'h0;
    logic [3:0] pipe [0:7];

    always #2 clk = ~clk;

    qspi_xip_reader u0 (
        .clk(clk), .rst_n(rst_n), .en(en),
        .cfg_div(cfg_div), .cfg_dummy(cfg_dummy), .cfg_dly(cfg_dly),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .sclk(sclk), .cs_n(cs_n), .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
    );

    function automatic logic [7:0] mem_byte(input logic [23:0] a);
        return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'h5A;
    endfunction

    // flash model: records every rising edge, drives read nibbles after falling edges
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cs_n) hc = hc + 1; else hc = 0;
        for (int i = 7; i > 0; i--) pipe[i] <= pipe[i-1];
        pipe[0] <= raw;
    end

    assign io_in = (lat == 0) ? raw : pipe[lat-1];

    always @(negedge cs_n) begin
        nr = 0;
        gap_last = hc;
    end

    always @(posedge sclk) begin
        if (!cs_n && nr < 64) begin
            rec_o[nr] = io_out;
            rec_e[nr] = io_oe;
            rise_cyc[nr] = cyc;
            nr = nr + 1;
        end
    end

    always @(negedge sclk) begin
        if (!cs_n) begin
            int cl;
            int pre;
            int j;
            logic [23:0] a;
            logic [7:0] b;
            cl = (rec_e[0] == 4'b0001) ? 8 : 0;
            pre = cl + 8 + int'(cfg_dummy);
            j = nr - pre;
            if (j >= 0 && j < 8) begin
                a = {rec_o[cl], rec_o[cl+1], rec_o[cl+2], rec_o[cl+3], rec_o[cl+4], rec_o[cl+5]};
                b = mem_byte(a + 24'(j / 2));
                raw = (j % 2 == 0) ? b[7:4] : b[3:0];
            end
        end
    end

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic do_read(input logic [23:0] addr, input bit want_cmd, input string tag_cmd, input string tag_dat);
        int w;
        int effdiv;
        int cl;
        bit busy_bad;
        bit ok;
        logic [31:0] got;
        logic [31:0] exp;
        logic [7:0] cb;
        logic [23:0] ra;
        logic [7:0] md;
        effdiv = (cfg_div == 0) ? 1 : int'(cfg_div);
        @(negedge clk);
        req_addr = addr;
        req_valid = 1'b1;
        w = 0;
        while (!req_ready && w < 1000) begin @(negedge clk); w++; end
        @(negedge clk);
        req_valid = 1'b0;
        busy_bad = 1'b0;
        w = 0;
        while (!rsp_valid && w < 5000) begin
            if (req_ready) busy_bad = 1'b1;
            @(negedge clk);
            w++;
        end
        chk(rsp_valid, "R7 response arrives", 32'(rsp_valid), 1);
        got = rsp_data;
        @(negedge clk);
        chk(!rsp_valid, "R7 single-cycle response", 32'(rsp_valid), 0);
        chk(!busy_bad, "R7 ready low while busy", 32'(busy_bad), 0);
        cl = (rec_e[0] == 4'b0001) ? 8 : 0;
        chk((cl == 8) == want_cmd, tag_cmd, 32'(cl), want_cmd ? 8 : 0);
        if (cl == 8) begin
            ok = 1'b1;
            for (int i = 0; i < 8; i++) begin
                cb[7-i] = rec_o[i][0];
                if (rec_e[i] != 4'b0001) ok = 1'b0;
            end
            chk(ok && cb == 8'hEB, "R1 serial command", 32'(cb), 32'hEB);
        end
        ok = 1'b1;
        for (int i = 0; i < 8; i++) if (rec_e[cl+i] != 4'b1111) ok = 1'b0;
        ra = {rec_o[cl], rec_o[cl+1], rec_o[cl+2], rec_o[cl+3], rec_o[cl+4], rec_o[cl+5]};
        md = {rec_o[cl+6], rec_o[cl+7]};
        chk(ok && ra == addr, "R2 quad address", 32'(ra), 32'(addr));
        chk(ok && md == 8'hA0, "R2 mode byte", 32'(md), 32'hA0);
        chk(nr == cl + 16 + int'(cfg_dummy), "R3 edge count", 32'(nr), 32'(cl + 16 + int'(cfg_dummy)));
        ok = 1'b1;
        for (int i = cl + 8; i < nr && i < 64; i++) if (rec_e[i] != 4'b0000) ok = 1'b0;
        chk(ok, "R3 lines released", 32'(ok), 1);
        exp = {mem_byte(addr + 24'd3), mem_byte(addr + 24'd2), mem_byte(addr + 24'd1), mem_byte(addr)};
        chk(got == exp, tag_dat, got, exp);
        chk(rise_cyc[1] - rise_cyc[0] == 2 * effdiv, "R9 sclk period",
            32'(rise_cyc[1] - rise_cyc[0]), 32'(2 * effdiv));
        chk(gap_last >= 2 * effdiv, "R8 deselect gap", 32'(gap_last), 32'(2 * effdiv));
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(cs_n == 1'b1 && sclk == 1'b0, "R11 pins idle", {30'd0, cs_n, sclk}, 32'h2);
        chk(io_oe == 4'b0000 && rsp_valid == 1'b0, "R11 outputs quiet", {27'd0, rsp_valid, io_oe}, 0);
        chk(req_ready == 1'b1, "R11 ready follows en", 32'(req_ready), 1);
    endtask

    task automatic t_first_then_cont();
        cfg_div = 4'd2; cfg_dummy = 4'd4; cfg_dly = 3'd1; lat = 0;
        do_read(24'h012340, 1'b1, "R1 command on first access", "R4 byte order");
        do_read(24'h0ABCD4, 1'b0, "R5 command omitted", "R4 byte order second");
    endtask

    task automatic t_fast_no_dummy();
        cfg_div = 4'd0; cfg_dummy = 4'd0; cfg_dly = 3'd0; lat = 0;
        do_read(24'hFFFFF8, 1'b0, "R5 continuous at fastest clock", "R3 data with no dummy");
    endtask

    task automatic t_capture_delay();
        cfg_div = 4'd2; cfg_dummy = 4'd6; cfg_dly = 3'd2; lat = 3;
        do_read(24'h5A5A00, 1'b0, "R5 continuous", "R10 delayed capture");
        lat = 0;
    endtask

    task automatic t_disable();
        bit moved;
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b0, "R6 ready low when disabled", 32'(req_ready), 0);
        req_valid = 1'b1;
        req_addr = 24'h000100;
        moved = 1'b0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (!cs_n) moved = 1'b1;
        end
        req_valid = 1'b0;
        chk(!moved, "R6 no transaction while disabled", 32'(moved), 0);
        en = 1'b1;
        cfg_div = 4'd3; cfg_dummy = 4'd4; cfg_dly = 3'd3;
        do_read(24'h00C0DC, 1'b1, "R6 command resent after enable", "R4 byte order after enable");
    endtask

    task automatic t_back_to_back();
        cfg_div = 4'd1; cfg_dummy = 4'd2; cfg_dly = 3'd1;
        do_read(24'h100000, 1'b0, "R5 continuous", "R4 back-to-back first");
        do_read(24'h100004, 1'b0, "R5 continuous", "R4 back-to-back second");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog expired: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) pipe[i] = 4'h0;
        for (int i = 0; i < 64; i++) begin
            rec_o[i] = 4'h0;
            rec_e[i] = 4'h0;
            rise_cyc[i] = 0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_first_then_cont();
        t_fast_no_dummy();
        t_capture_delay();
        t_disable();
        t_back_to_back();
        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule